// File: doc/BRIEF.md
# Byte-Lane Word Writer

This block turns a byte stream into a series of 32-bit word writes for a memory or bus that takes a per-byte select mask. A one-cycle start pulse supplies a byte address and a byte count. The bytes then arrive over a valid/ready handshake. The block packs them into word lanes, most significant lane first, and presents each finished word on a write request port with its aligned address, data and select mask. The request is held until the receiver signals ready.

The start address need not be word-aligned. When it is not, the first write goes to the aligned word below the start address and enables only the lanes from the start offset onward. Full words follow. A final partial word enables only the leading lanes and leaves the unused lanes at zero. A frame that starts and ends inside one word produces a single write whose mask covers exactly the bytes present. A one-cycle done pulse marks the end of each frame.

Top module: `lane_writer`

## Requirements
- R1: A byte whose address has low bits 0, 1, 2 or 3 is placed in data bits 31:24, 23:16, 15:8 or 7:0 respectively, with select bit 3, 2, 1 or 0 set. A complete word therefore carries select 4'hF, and its first byte is in bits 31:24.
- R2: The first write of a frame whose start address has low bits 1, 2 or 3 goes to the address with those bits cleared. It uses select 4'h7, 4'h3 or 4'h1 and carries 3, 2 or 1 bytes, as long as the frame reaches the end of that word.
- R3: A last word holding 3, 2 or 1 bytes that starts on a word boundary uses select 4'hE, 4'hC or 4'h8. Its data bits in unselected lanes are zero.
- R4: Each write after the first in a frame has an address 4 higher than the previous write of that frame.
- R5: A start with length 0 produces no write, and done is high in the cycle after the start is sampled.
- R6: A frame that begins and ends within one word produces exactly one write. Its select bits are set only for the lanes of the bytes present (for example, start low bits 1 with length 2 gives select 4'h6).
- R7: Done is high for exactly one cycle: the cycle after the final write is accepted (wr_valid_o and wr_ready_i both high at a rising edge). It is low at all other times.
- R8: While wr_valid_o is high and wr_ready_i is low, wr_valid_o stays high and the address, data and select stay unchanged.
- R9: byte_ready_o is never high while a write request is pending. Bytes are taken only when byte_valid_i and byte_ready_o are both high, and they are packed in arrival order.
- R10: A start pulse that arrives while a frame is in progress is ignored. The writes of the running frame are unchanged.
- R11: After reset, wr_valid_o, byte_ready_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start pulse |
| start_addr_i | input | AW (32) | Byte address of the first byte |
| start_len_i | input | LW (16) | Byte count of the frame |
| byte_valid_i | input | 1 | Input byte valid |
| byte_data_i | input | 8 | Input byte |
| byte_ready_o | output | 1 | Block can take a byte |
| wr_valid_o | output | 1 | Write request pending |
| wr_addr_o | output | AW (32) | Word-aligned write address |
| wr_data_o | output | 8*LANES (32) | Write data, first lane in the top byte |
| wr_sel_o | output | LANES (4) | Byte-select mask, bit 3 for bits 31:24 |
| wr_ready_i | input | 1 | Receiver accepts the write |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The checker watches several properties on every cycle. It confirms that a stalled write request stays stable, that no byte is accepted while a write is pending, and that done never lasts longer than one cycle. It also checks that unselected lanes carry zero data and that write addresses within a frame step by one word. The rest depends on the exact bytes of a frame, so only the bench scenarios can show it. That covers which lanes and masks the head and tail writes get for each start offset and length, the single-write case for short frames, zero-length frames, and a start pulse that arrives in the middle of a frame and must be ignored.

// File: rtl/lane_writer_pkg.sv
package lane_writer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_SEND = 2'd2
   } lw_state_e;
endpackage

// File: rtl/lane_writer_merge.sv
// Lane accumulator: one register slice per byte lane. Lane j holds the byte
// whose word offset is LANES-1-j, so offset 0 lands in the top lane.
module lane_writer_merge #(
   parameter int LANES = 4,
   localparam int OW = $clog2(LANES),
   localparam int DW = 8 * LANES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          load_i,
   input  logic [OW-1:0] off_i,
   input  logic [7:0]    byte_i,
   output logic [DW-1:0] data_o,
   output logic [LANES-1:0] sel_o
);
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam logic [OW-1:0] MY_OFF = OW'(LANES - 1 - j);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_o[8*j +: 8] <= '0;
            sel_o[j]         <= 1'b0;
         end else if (clear_i) begin
            data_o[8*j +: 8] <= '0;
            sel_o[j]         <= 1'b0;
         end else if (load_i && (off_i == MY_OFF)) begin
            data_o[8*j +: 8] <= byte_i;
            sel_o[j]         <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/lane_writer_ctrl.sv
// Frame sequencer: tracks the lane offset, remaining bytes and word address.
module lane_writer_ctrl
   import lane_writer_pkg::*;
#(
   parameter int LANES = 4,
   parameter int AW = 32,
   parameter int LW = 16,
   localparam int OW = $clog2(LANES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] start_addr_i,
   input  logic [LW-1:0] start_len_i,
   input  logic          byte_valid_i,
   output logic          byte_ready_o,
   input  logic          wr_ready_i,
   output logic          wr_valid_o,
   output logic [AW-1:0] wr_addr_o,
   output logic          done_o,
   output logic          take_o,
   output logic          clear_o,
   output logic [OW-1:0] off_o
);
   lw_state_e     state_q;
   logic [OW-1:0] off_q;
   logic [LW-1:0] rem_q;
   logic [AW-1:0] waddr_q;
   logic          done_q;
   logic          fire;
   logic          word_end;

   assign byte_ready_o = (state_q == ST_FILL);
   assign wr_valid_o   = (state_q == ST_SEND);
   assign take_o       = byte_ready_o && byte_valid_i;
   assign fire         = wr_valid_o && wr_ready_i;
   assign clear_o      = fire;
   assign off_o        = off_q;
   assign wr_addr_o    = waddr_q;
   assign done_o       = done_q;
   assign word_end     = (off_q == OW'(LANES - 1)) || (rem_q == LW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         off_q   <= '0;
         rem_q   <= '0;
         waddr_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (start_len_i == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= ST_FILL;
                     off_q   <= start_addr_i[OW-1:0];
                     rem_q   <= start_len_i;
                     waddr_q <= {start_addr_i[AW-1:OW], {OW{1'b0}}};
                  end
               end
            end
            ST_FILL: begin
               if (take_o) begin
                  rem_q <= rem_q - LW'(1);
                  off_q <= off_q + OW'(1);
                  if (word_end) state_q <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (fire) begin
                  if (rem_q == '0) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= ST_FILL;
                     off_q   <= '0;
                     waddr_q <= waddr_q + AW'(LANES);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lane_writer.sv
module lane_writer #(
   parameter int LANES = 4,
   parameter int AW = 32,
   parameter int LW = 16,
   localparam int OW = $clog2(LANES),
   localparam int DW = 8 * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [AW-1:0]    start_addr_i,
   input  logic [LW-1:0]    start_len_i,
   input  logic             byte_valid_i,
   input  logic [7:0]       byte_data_i,
   output logic             byte_ready_o,
   output logic             wr_valid_o,
   output logic [AW-1:0]    wr_addr_o,
   output logic [DW-1:0]    wr_data_o,
   output logic [LANES-1:0] wr_sel_o,
   input  logic             wr_ready_i,
   output logic             done_o
);
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (AW <= OW) begin : g_bad_aw
      $error("AW must exceed the lane offset width");
   end
   if (LW < 1) begin : g_bad_lw
      $error("LW must be at least 1");
   end

   logic          take;
   logic          clear;
   logic [OW-1:0] off;

   lane_writer_ctrl #(.LANES(LANES), .AW(AW), .LW(LW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .start_addr_i (start_addr_i),
      .start_len_i  (start_len_i),
      .byte_valid_i (byte_valid_i),
      .byte_ready_o (byte_ready_o),
      .wr_ready_i   (wr_ready_i),
      .wr_valid_o   (wr_valid_o),
      .wr_addr_o    (wr_addr_o),
      .done_o       (done_o),
      .take_o       (take),
      .clear_o      (clear),
      .off_o        (off)
   );

   lane_writer_merge #(.LANES(LANES)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .load_i  (take),
      .off_i   (off),
      .byte_i  (byte_data_i),
      .data_o  (wr_data_o),
      .sel_o   (wr_sel_o)
   );
endmodule

// File: rtl/lane_writer_chk.sv
module lane_writer_chk #(
   parameter int LANES = 4,
   parameter int AW = 32,
   localparam int DW = 8 * LANES
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_valid_o,
   input logic             wr_ready_i,
   input logic [AW-1:0]    wr_addr_o,
   input logic [DW-1:0]    wr_data_o,
   input logic [LANES-1:0] wr_sel_o,
   input logic             byte_ready_o,
   input logic             done_o
);
   logic [LANES-1:0] lane_ok;
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign lane_ok[j] = wr_sel_o[j] || (wr_data_o[8*j +: 8] == 8'h00);
   end

   logic          have_prev;
   logic [AW-1:0] prev_addr;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_addr <= '0;
      end else if (done_o) begin
         have_prev <= 1'b0;
      end else if (wr_valid_o && wr_ready_i) begin
         have_prev <= 1'b1;
         prev_addr <= wr_addr_o;
      end
   end

   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o)
                                    && $stable(wr_data_o) && $stable(wr_sel_o));

   assert_no_take_while_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid_o && byte_ready_o));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !wr_valid_o);

   assert_unused_lane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> (&lane_ok));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && have_prev |-> wr_addr_o == prev_addr + AW'(LANES));
endmodule

bind lane_writer lane_writer_chk #(.LANES(LANES), .AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_valid_o   (wr_valid_o),
   .wr_ready_i   (wr_ready_i),
   .wr_addr_o    (wr_addr_o),
   .wr_data_o    (wr_data_o),
   .wr_sel_o     (wr_sel_o),
   .byte_ready_o (byte_ready_o),
   .done_o       (done_o)
);

// File: tb/lane_writer_bench.sv
`timescale 1ns/100ps
module lane_writer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] start_addr_i = '0;
   logic [15:0] start_len_i = '0;
   logic        byte_valid_i = 1'b0;
   logic [7:0]  byte_data_i = '0;
   logic        byte_ready_o;
   logic        wr_valid_o;
   logic [31:0] wr_addr_o;
   logic [31:0] wr_data_o;
   logic [3:0]  wr_sel_o;
   logic        wr_ready_i = 1'b0;
   logic        done_o;

   always #2.5 clk = ~clk;

   lane_writer u_lane_writer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .start_len_i(start_len_i), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
      .byte_ready_o(byte_ready_o), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .wr_sel_o(wr_sel_o), .wr_ready_i(wr_ready_i), .done_o(done_o)
   );

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0]  stim [0:127];
   logic [31:0] exp_addr [0:40];
   logic [31:0] exp_data [0:40];
   logic [3:0]  exp_sel  [0:40];
   string       exp_tag  [0:40];
   int          exp_n;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // Expected writes from the lane rule: offset o goes to lane 3-o.
   task automatic build_expect(input logic [31:0] addr, input int len);
      exp_n = 0;
      for (int i = 0; i < len; i++) begin
         logic [31:0] a;
         int o;
         a = addr + 32'(i);
         o = int'(a[1:0]);
         if (i == 0 || o == 0) begin
            exp_addr[exp_n] = {a[31:2], 2'b00};
            exp_data[exp_n] = '0;
            exp_sel[exp_n]  = '0;
            exp_n++;
         end
         exp_data[exp_n-1][8*(3-o) +: 8] = stim[i];
         exp_sel[exp_n-1][3-o] = 1'b1;
      end
      for (int k = 0; k < exp_n; k++) begin
         if (exp_n == 1 && exp_sel[k] != 4'hF)      exp_tag[k] = "R6";
         else if (k == 0 && exp_sel[k] != 4'hF)     exp_tag[k] = "R2";
         else if (k == exp_n-1 && exp_sel[k] != 4'hF) exp_tag[k] = "R3";
         else                                       exp_tag[k] = "R1";
      end
   endtask

   task automatic run_frame(input logic [31:0] addr, input int len, input int rdy_pct, input bit poke);
      int wi, bi;
      bit dpend, seen, bad8, bad9, held_v;
      logic [67:0] held;
      for (int i = 0; i < len; i++) stim[i] = 8'($urandom);
      build_expect(addr, len);
      @(negedge clk);
      start_i = 1'b1; start_addr_i = addr; start_len_i = 16'(len);
      wi = 0; bi = 0; dpend = (len == 0); seen = 0; bad8 = 0; bad9 = 0; held_v = 0; held = '0;
      for (int cyc = 0; cyc < 4000; cyc++) begin
         @(negedge clk);
         if (poke && cyc == 5) begin
            start_i = 1'b1; start_addr_i = 32'h0000_0999; start_len_i = 16'd7;  // R10 stray start
         end else begin
            start_i = 1'b0;
         end
         byte_valid_i = (bi < len) && ($urandom % 100 < 80);
         byte_data_i  = (bi < len) ? stim[bi] : 8'h00;
         wr_ready_i   = ($urandom % 100) < 32'(rdy_pct);
         #1;
         if (held_v && (!wr_valid_o || {wr_addr_o, wr_data_o, wr_sel_o} != held)) bad8 = 1;
         held_v = wr_valid_o && !wr_ready_i;
         held   = {wr_addr_o, wr_data_o, wr_sel_o};
         if (wr_valid_o && byte_ready_o) bad9 = 1;
         if (wr_valid_o && wr_ready_i) begin
            if (wi < exp_n) begin
               chk(wr_addr_o == exp_addr[wi], "R4", 64'(wr_addr_o), 64'(exp_addr[wi]));
               chk({wr_data_o, wr_sel_o} == {exp_data[wi], exp_sel[wi]}, exp_tag[wi],
                   64'({wr_data_o, wr_sel_o}), 64'({exp_data[wi], exp_sel[wi]}));
            end else begin
               chk(1'b0, "R10", 64'(wi), 64'(exp_n));
            end
            wi++;
            if (wi == exp_n) dpend = 1;
         end else if (byte_valid_i && byte_ready_o) begin
            bi++;
         end
         if (dpend && !(wr_valid_o && wr_ready_i)) begin
            chk(done_o == 1'b1, (len == 0) ? "R5" : "R7", 64'(done_o), 64'd1);
            seen = 1;
            break;
         end else if (done_o) begin
            chk(1'b0, "R7", 64'(done_o), 64'd0);
         end
      end
      start_i = 1'b0; byte_valid_i = 1'b0; wr_ready_i = 1'b0;
      if (!seen) chk(1'b0, "R7", 64'd0, 64'd1);
      chk(wi == exp_n, (len == 0) ? "R5" : "R10", 64'(wi), 64'(exp_n));
      chk(!bad8, "R8", 64'(bad8), 64'd0);
      chk(!bad9, "R9", 64'(bad9), 64'd0);
      @(negedge clk);
      #1;
      chk(done_o == 1'b0, "R7", 64'(done_o), 64'd0);
   endtask

   initial begin
      #750000;
      chk(1'b0, "watchdog", 64'd0, 64'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      #1;
      chk({wr_valid_o, byte_ready_o, done_o} == 3'b000, "R11",
          64'({wr_valid_o, byte_ready_o, done_o}), 64'd0);
      rst_n = 1'b1;
      run_frame(32'h0000_0100, 8, 100, 0);   // R1 aligned full words
      run_frame(32'h0000_0101, 10, 60, 0);   // R2 head 4'h7, R3 tail
      run_frame(32'h0000_0102, 9, 60, 0);    // R2 head 4'h3
      run_frame(32'h0000_0103, 6, 60, 0);    // R2 head 4'h1, R3 tail 4'h8
      run_frame(32'h0000_0100, 3, 50, 0);    // R6 single write 4'hE
      run_frame(32'h0000_0200, 0, 50, 0);    // R5 zero length
      run_frame(32'h0000_0301, 2, 50, 0);    // R6 mask 4'h6
      run_frame(32'h0000_0303, 1, 50, 0);    // R6 mask 4'h1
      run_frame(32'h0000_0400, 40, 30, 1);   // R10 stray start
      run_frame(32'hFFFF_FFFE, 7, 70, 0);    // R4 address wrap
      for (int n = 0; n < 40; n++)
         run_frame($urandom, int'($urandom % 65), 20 + int'($urandom % 81), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule